// File: doc/BRIEF.md
# Shift-Register Handshake Transaction Controller

This controller sits on the host side of an 8-bit serial shift-register link to a peripheral microcontroller. It moves whole byte packets in both directions. Two host-driven handshake lines frame the traffic: `tip` stays low for the length of a packet, and `tack` toggles once for each byte. The device drives an active-low request line, `dev_req_n`. The device pulls it low to announce data or to ask for more time. The host reads it high as "device idle, or device finished".

The shift register sits outside this block. It raises `sr_done` for one cycle each time a byte has been shifted. On input it offers the received byte on `sr_rdata`. On output it accepts a byte on `sr_wdata` when `sr_load` pulses, and `sr_dir_out` selects the shift direction.

Inbound packets are collected into a 16-byte buffer and announced with a one-cycle `rx_valid` pulse and a length. Outbound packets of 2 to 8 bytes are handed over through `tx_req`. A packet stays pending until it has gone out completely. When the device claims the link during the first byte, that attempt is dropped and the packet is sent again later. Bit shifting, clock generation and packet meaning are handled elsewhere.

Top module: `shreg_link_ctrl`

## Requirements
- R1: After reset `busy` is 0, `tip` and `tack` are 1, `sr_dir_out` is 0, `tx_pend` is 0 and `rx_valid` is 0.
- R2: While idle, a `sr_done` strobe with `dev_req_n` high is ignored: `busy`, `tip` and `tack` keep their values.
- R3: While idle, a `sr_done` strobe with `dev_req_n` low discards that byte, drives `tip` low and makes the block busy (receiving).
- R4: While receiving, each byte is stored. If `dev_req_n` is low at the strobe, `tack` toggles. If `dev_req_n` is high, that byte is the last one, `tip` and `tack` both go high, and the block waits for one closing strobe.
- R5: The closing strobe produces a one-cycle `rx_valid` pulse in the cycle after it. With that pulse, `rx_len` gives the number of stored bytes, and stored byte i appears on `rx_data[8*i+7:8*i]`.
- R6: Bytes beyond 16 in one packet are dropped without notice, and `rx_len` saturates at 16.
- R7: If `dev_req_n` is low at the closing strobe, a second packet follows back to back. `tip` goes low again, the block stays busy, and the next strobe is stored as byte 0 of the new packet.
- R8: `tx_req` is taken only when `tx_pend` is 0 and `tx_len` is between 2 and 8. Otherwise it is ignored and `tx_pend` stays 0.
- R9: A send starts only while idle, with a packet pending and `dev_req_n` high. That cycle's strobe, if any, is the ignored one of R2. In the cycle after start, `sr_dir_out` is 1, `sr_load` pulses with byte 0 on `sr_wdata`, and `tip` is 0.
- R10: A strobe with `dev_req_n` low during byte 0 is a collision. The block then returns idle with `sr_dir_out` 0 and `tip` and `tack` 1, keeps `tx_pend` at 1, and starts the same packet again once `dev_req_n` is high.
- R11: Without a collision, each strobe loads the next byte (byte k with `sr_load`) and toggles `tack`. The strobe after the last byte clears `tx_pend`, sets `sr_dir_out` to 0, drives `tip` and `tack` high and returns idle.
- R12: `busy` is 1 exactly when the block is not idle, and while idle `tip` and `tack` are 1 and `sr_dir_out` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dev_req_n | input | 1 | Device request, active low |
| tip | output | 1 | Packet framing line, low during a transfer |
| tack | output | 1 | Per-byte acknowledge, toggles per byte |
| sr_done | input | 1 | Byte-complete strobe from the shift register |
| sr_rdata | input | 8 | Byte shifted in |
| sr_wdata | output | 8 | Byte to shift out |
| sr_load | output | 1 | Load pulse for sr_wdata |
| sr_dir_out | output | 1 | Shift direction, 1 = host to device |
| tx_req | input | 1 | Request to queue an outbound packet |
| tx_len | input | 4 | Outbound length in bytes |
| tx_data | input | 64 | Outbound bytes, byte i at bits 8i+7:8i |
| tx_pend | output | 1 | An outbound packet is pending |
| rx_valid | output | 1 | Inbound packet complete, one-cycle pulse |
| rx_len | output | 5 | Inbound length in bytes |
| rx_data | output | 128 | Inbound bytes, byte i at bits 8i+7:8i |
| busy | output | 1 | Block is not idle |

## Verification
Two events can meet in one cycle while the block is idle. A stray strobe with the request line high can coincide with the start of a pending send; the bench provokes this when it retries after a collision, by raising `dev_req_n` and `sr_done` together. It expects the send to start, with byte 0 loaded one cycle later. A new `tx_req` can also land on the very strobe that ends a send. The bench drives both together and expects `tx_pend` to end low, with no load pulse in the idle cycles that follow, because the request arrived while the old packet was still pending.

// File: rtl/shreg_link_ctrl.sv
module shreg_link_ctrl #(
  parameter int RX_DEPTH = 16,
  parameter int TX_DEPTH = 8,
  localparam int RXW = $clog2(RX_DEPTH + 1),
  localparam int TXW = $clog2(TX_DEPTH + 1)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  dev_req_n,
  output logic                  tip,
  output logic                  tack,
  input  logic                  sr_done,
  input  logic [7:0]            sr_rdata,
  output logic [7:0]            sr_wdata,
  output logic                  sr_load,
  output logic                  sr_dir_out,
  input  logic                  tx_req,
  input  logic [TXW-1:0]        tx_len,
  input  logic [8*TX_DEPTH-1:0] tx_data,
  output logic                  tx_pend,
  output logic                  rx_valid,
  output logic [RXW-1:0]        rx_len,
  output logic [8*RX_DEPTH-1:0] rx_data,
  output logic                  busy
);
  localparam int IW  = (RXW > TXW) ? RXW : TXW;
  localparam int RXI = $clog2(RX_DEPTH);
  localparam int TXI = $clog2(TX_DEPTH);

  typedef enum logic [2:0] {S_IDLE, S_RX, S_RXEND, S_SSTART, S_SEND} st_t;

  st_t            st;
  logic [IW-1:0]  idx;
  logic [TXW-1:0] pend_len;
  logic [7:0]     rxb [RX_DEPTH];
  logic [7:0]     txb [TX_DEPTH];

  wire accept = tx_req && (pend_len == '0) &&
                (tx_len >= TXW'(2)) && (tx_len <= TXW'(TX_DEPTH));
  wire start  = (st == S_IDLE) && (pend_len != '0) && dev_req_n;
  wire rx_store = sr_done && (st == S_RX) && (idx < IW'(RX_DEPTH));

  assign busy    = (st != S_IDLE);
  assign tx_pend = (pend_len != '0);

  for (genvar g = 0; g < RX_DEPTH; g++) begin : g_rx
    assign rx_data[8*g +: 8] = rxb[g];
  end

  always_ff @(posedge clk) begin
    if (rx_store) rxb[idx[RXI-1:0]] <= sr_rdata;
    if (accept)
      for (int i = 0; i < TX_DEPTH; i++) txb[i] <= tx_data[8*i +: 8];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st         <= S_IDLE;
      idx        <= '0;
      pend_len   <= '0;
      tip        <= 1'b1;
      tack       <= 1'b1;
      sr_dir_out <= 1'b0;
      sr_load    <= 1'b0;
      sr_wdata   <= '0;
      rx_valid   <= 1'b0;
      rx_len     <= '0;
    end else begin
      sr_load  <= 1'b0;
      rx_valid <= 1'b0;
      if (accept) pend_len <= tx_len;
      case (st)
        S_IDLE: begin
          if (sr_done && !dev_req_n) begin
            tip <= 1'b0;
            idx <= '0;
            st  <= S_RX;
          end else if (start) begin
            sr_dir_out <= 1'b1;
            sr_wdata   <= txb[0];
            sr_load    <= 1'b1;
            tip        <= 1'b0;
            st         <= S_SSTART;
          end
        end
        S_RX: if (sr_done) begin
          if (idx < IW'(RX_DEPTH)) idx <= idx + 1'b1;
          if (!dev_req_n) tack <= ~tack;
          else begin
            tack <= 1'b1;
            tip  <= 1'b1;
            st   <= S_RXEND;
          end
        end
        S_RXEND: if (sr_done) begin
          rx_valid <= 1'b1;
          rx_len   <= RXW'(idx);
          idx      <= '0;
          if (!dev_req_n) begin
            tip <= 1'b0;
            st  <= S_RX;
          end else st <= S_IDLE;
        end
        S_SSTART: if (sr_done) begin
          if (!dev_req_n) begin
            sr_dir_out <= 1'b0;
            tip        <= 1'b1;
            tack       <= 1'b1;
            st         <= S_IDLE;
          end else begin
            sr_wdata <= txb[1];
            sr_load  <= 1'b1;
            tack     <= ~tack;
            idx      <= IW'(2);
            st       <= S_SEND;
          end
        end
        S_SEND: if (sr_done) begin
          if (idx < IW'(pend_len)) begin
            sr_wdata <= txb[idx[TXI-1:0]];
            sr_load  <= 1'b1;
            tack     <= ~tack;
            idx      <= idx + 1'b1;
          end else begin
            pend_len   <= '0;
            idx        <= '0;
            sr_dir_out <= 1'b0;
            tip        <= 1'b1;
            tack       <= 1'b1;
            st         <= S_IDLE;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

module shreg_link_ctrl_chk #(
  parameter int RX_DEPTH = 16,
  localparam int RXW = $clog2(RX_DEPTH + 1)
) (
  input logic           clk,
  input logic           rst_n,
  input logic           dev_req_n,
  input logic           tip,
  input logic           tack,
  input logic           sr_done,
  input logic           sr_load,
  input logic           sr_dir_out,
  input logic           tx_pend,
  input logic           rx_valid,
  input logic [RXW-1:0] rx_len,
  input logic           busy
);
  a_r12_idle_lines: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (tip && tack && !sr_dir_out));
  a_r9_load_dir_out: assert property (@(posedge clk) disable iff (!rst_n)
    sr_load |-> sr_dir_out);
  a_r4_tack_on_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(tack) |-> $past(sr_done));
  a_r9_start_idle_req_high: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sr_dir_out) |-> ($past(dev_req_n) && !$past(busy) && $past(tx_pend)));
  a_r11_pend_clear_idle: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(tx_pend) |-> (!busy && !sr_dir_out && $past(sr_done)));
  a_r6_len_bound: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |-> (rx_len <= RXW'(RX_DEPTH) && rx_len != '0));
  a_r5_valid_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> !rx_valid);
endmodule

bind shreg_link_ctrl shreg_link_ctrl_chk #(.RX_DEPTH(RX_DEPTH)) u_chk (.*);

// File: tb/shreg_link_ctrl_bench.sv
module shreg_link_ctrl_bench;
  localparam int CLK_PERIOD = 10;
  localparam int RXD = 16;
  localparam int TXD = 8;

  logic clk = 0, rst_n = 0, dev_req_n = 1, sr_done = 0, tx_req = 0;
  logic [7:0] sr_rdata = 0;
  logic [3:0] tx_len = 0;
  logic [8*TXD-1:0] tx_data = 0;
  logic tip, tack, sr_load, sr_dir_out, tx_pend, rx_valid, busy;
  logic [7:0] sr_wdata;
  logic [4:0] rx_len;
  logic [8*RXD-1:0] rx_data;
  int checks = 0, fails = 0;
  bit done_flag = 0;

  shreg_link_ctrl u_shreg_link_ctrl (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic strobe(input logic [7:0] d, input logic rq);
    sr_rdata = d; dev_req_n = rq; sr_done = 1;
    @(negedge clk);
    sr_done = 0;
  endtask

  function automatic logic [7:0] rxpat(input int l, input int i);
    return 8'((i * 7 + l * 5 + 1) & 255);
  endfunction

  function automatic logic [7:0] txpat(input int l, input int k);
    return 8'((k * 13 + l * 3 + 8'h40) & 255);
  endfunction

  task automatic rx_body(input int l);
    for (int i = 0; i < l; i++) begin
      strobe(rxpat(l, i), (i == l - 1) ? 1'b1 : 1'b0);
      if (i < l - 1) chk("R4 tack toggle", int'(tack), ((i + 1) % 2 == 0) ? 1 : 0);
      else begin
        chk("R4 last tip", int'(tip), 1);
        chk("R4 last tack", int'(tack), 1);
      end
    end
  endtask

  task automatic rx_result(input int l);
    int n;
    n = (l > RXD) ? RXD : l;
    chk("R5 rx_valid", int'(rx_valid), 1);
    chk("R6 rx_len", int'(rx_len), n);
    for (int i = 0; i < n; i++)
      chk("R5 rx_data", int'(rx_data[8*i +: 8]), int'(rxpat(l, i)));
  endtask

  task automatic queue_tx(input int l);
    for (int k = 0; k < TXD; k++) tx_data[8*k +: 8] = txpat(l, k);
    tx_len = 4'(l); tx_req = 1; dev_req_n = 1;
    @(negedge clk);
    tx_req = 0;
  endtask

  task automatic check_started(input int l);
    chk("R9 load", int'(sr_load), 1);
    chk("R9 dir_out", int'(sr_dir_out), 1);
    chk("R9 byte0", int'(sr_wdata), int'(txpat(l, 0)));
    chk("R9 tip low", int'(tip), 0);
  endtask

  task automatic finish_tx(input int l);
    for (int j = 1; j < l; j++) begin
      strobe(8'h00, 1'b1);
      chk("R11 load", int'(sr_load), 1);
      chk("R11 byte", int'(sr_wdata), int'(txpat(l, j)));
      chk("R11 tack", int'(tack), (j % 2 == 0) ? 1 : 0);
    end
    strobe(8'h00, 1'b1);
    chk("R11 pend cleared", int'(tx_pend), 0);
    chk("R11 dir in", int'(sr_dir_out), 0);
    chk("R11 tip", int'(tip), 1);
    chk("R11 tack", int'(tack), 1);
    chk("R12 busy", int'(busy), 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done_flag) begin
      fails++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1 busy", int'(busy), 0);
    chk("R1 tip", int'(tip), 1);
    chk("R1 tack", int'(tack), 1);
    chk("R1 dir", int'(sr_dir_out), 0);
    chk("R1 pend", int'(tx_pend), 0);
    chk("R1 rx_valid", int'(rx_valid), 0);

    strobe(8'hAA, 1'b1);
    chk("R2 busy", int'(busy), 0);
    chk("R2 tip", int'(tip), 1);
    chk("R2 tack", int'(tack), 1);

    for (int l = 1; l <= 20; l++) begin
      strobe(8'hEE, 1'b0);
      chk("R3 tip low", int'(tip), 0);
      chk("R3 busy", int'(busy), 1);
      rx_body(l);
      strobe(8'h00, 1'b1);
      rx_result(l);
      chk("R12 idle after rx", int'(busy), 0);
      @(negedge clk);
      chk("R5 pulse ends", int'(rx_valid), 0);
    end

    strobe(8'hEE, 1'b0);
    rx_body(4);
    strobe(8'h00, 1'b0);
    rx_result(4);
    chk("R7 tip low again", int'(tip), 0);
    chk("R7 busy", int'(busy), 1);
    rx_body(3);
    strobe(8'h00, 1'b1);
    rx_result(3);

    tx_len = 4'd1; tx_req = 1; dev_req_n = 1;
    @(negedge clk);
    tx_len = 4'd9;
    @(negedge clk);
    tx_req = 0;
    chk("R8 bad len ignored", int'(tx_pend), 0);
    @(negedge clk);
    chk("R8 no start", int'(busy), 0);

    for (int l = 2; l <= TXD; l++) begin
      queue_tx(l);
      chk("R8 pend", int'(tx_pend), 1);
      @(negedge clk);
      check_started(l);
      finish_tx(l);
    end

    queue_tx(3);
    @(negedge clk);
    check_started(3);
    strobe(8'h00, 1'b0);
    chk("R10 idle", int'(busy), 0);
    chk("R10 dir in", int'(sr_dir_out), 0);
    chk("R10 tip", int'(tip), 1);
    chk("R10 tack", int'(tack), 1);
    chk("R10 pend kept", int'(tx_pend), 1);
    repeat (3) @(negedge clk);
    chk("R10 waits", int'(busy), 0);
    chk("R10 no load", int'(sr_load), 0);
    strobe(8'h5A, 1'b1);
    chk("R9 retry busy", int'(busy), 1);
    check_started(3);
    finish_tx(3);

    queue_tx(2);
    @(negedge clk);
    check_started(2);
    strobe(8'h00, 1'b1);
    chk("R11 byte1", int'(sr_wdata), int'(txpat(2, 1)));
    for (int k = 0; k < TXD; k++) tx_data[8*k +: 8] = txpat(5, k);
    tx_len = 4'd5; tx_req = 1;
    strobe(8'h00, 1'b1);
    tx_req = 0;
    chk("R8 req during last byte ignored", int'(tx_pend), 0);
    chk("R11 idle", int'(busy), 0);
    repeat (2) @(negedge clk);
    chk("R8 no new start", int'(sr_load), 0);
    chk("R8 still idle", int'(busy), 0);

    done_flag = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule